// File: doc/BRIEF.md
# Hexadecimal Floating-Point Halve Unit

This unit divides a base-16 floating-point number by two. The operand has a sign bit, a 7-bit characteristic in excess-64 notation and a fraction of hexadecimal digits. The unit first moves the fraction right by one bit. The bit that drops off the right end becomes the top bit of a four-bit guard digit. The unit then renormalizes by whole hex digits, with the guard digit taking part, and cuts the result back to the fraction width of the selected format. It also handles exponent underflow under a mask bit, gives zero operands a true-zero result, and checks that both register designators name an even register below eight.

A request is accepted with a valid/ready handshake. The result is registered and offered one cycle later on an output valid/ready pair. A result that the consumer has not taken stays on the output unchanged. The condition code is outside this unit and is never affected.

Top module: `hfp_halve`

## Requirements
- R1: With `fmt_long`=0 the operand occupies `operand[31:0]`: sign in bit 31, characteristic in bits 30:24 and a 24-bit fraction in bits 23:0. Bits 63:32 are ignored and `result[63:32]` is zero. With `fmt_long`=1 the sign is bit 63, the characteristic is bits 62:56 and the 56-bit fraction is bits 55:0.
- R2: A nonzero fraction whose leading hex digit is 2 or more keeps its characteristic. Its fraction becomes the input fraction shifted right one bit, truncated to the format width.
- R3: When the shifted value (fraction plus guard digit) has leading zero hex digits, it is shifted left by whole digits until the top digit is nonzero. The characteristic drops by one per digit, and the guard digit supplies the lowest result digit.
- R4: If the final characteristic would be below zero and `um_en`=1, the result carries that characteristic plus 128, keeps the correct sign and fraction, and `uf_flag`=1.
- R5: If the final characteristic would be below zero and `um_en`=0, the result is all zeros and `uf_flag`=0.
- R6: An input fraction of zero gives an all-zero result with `uf_flag`=0, whatever the sign and characteristic.
- R7: The result sign equals the operand sign, except that any true-zero result has sign 0.
- R8: Each of `r1` and `r2` must be 0, 2, 4 or 6. Otherwise `spec_err`=1, `wr_en`=0, `uf_flag`=0 and `result` is zero. A valid pair gives `spec_err`=0 and `wr_en`=1.
- R9: A request is taken on a rising edge with `in_valid` and `in_ready` both high, and its result shows with `out_valid`=1 after that edge. `in_ready` equals `!out_valid || out_ready`.
- R10: While `out_valid`=1 and `out_ready`=0, all outputs hold their values.
- R11: During reset `out_valid`=0 and `in_ready`=1. Results leave in the order their requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| fmt_long | input | 1 | 1 = long format, 0 = short format |
| r1 | input | 4 | Result register designator |
| r2 | input | 4 | Operand register designator |
| um_en | input | 1 | Exponent-underflow mask |
| operand | input | 64 | Operand to halve |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Halved, normalized value |
| wr_en | output | 1 | Result may be written to the register |
| spec_err | output | 1 | Register designator check failed |
| uf_flag | output | 1 | Exponent underflow reported |

## Verification
Almost all state is the one-deep output register. A wrong digit count in normalization appears as a wrong characteristic and a fraction off by one hex digit on the very result that follows the request. A corrupted valid bit or stall path appears within one cycle, as a lost, duplicated or changed result while the consumer holds off. Underflow and zero paths each change the output fields of that same transfer, so a fault shows at the first operand that reaches them.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int EXP_W    = 7;
  localparam int SHORT_FW = 24;
  localparam int LONG_FW  = 56;
  localparam int DIG_W    = 4;
  localparam int WORD_W   = 64;
  localparam int REG_W    = 4;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              wr;
    logic              spec;
    logic              uf;
  } hfp_res_t;
endpackage

// File: rtl/hfp_norm.sv
module hfp_norm #(
  parameter int FW    = 56,
  parameter int DIG_W = 4,
  localparam int EXT_W = FW + DIG_W,
  localparam int NDIG  = EXT_W / DIG_W,
  localparam int CNT_W = $clog2(NDIG + 1)
) (
  input  logic [FW-1:0]    frac_i,
  output logic [FW-1:0]    frac_o,
  output logic [CNT_W-1:0] shift_o,
  output logic             zero_o
);
  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] shifted;
  logic [CNT_W-1:0] lead;
  logic             seen;

  // one-bit right shift, dropped bit lands in guard digit MSB
  assign ext = {1'b0, frac_i, {(DIG_W-1){1'b0}}};

  always_comb begin
    lead = '0;
    seen = 1'b0;
    for (int d = NDIG - 1; d >= 0; d--) begin
      if (!seen) begin
        if (ext[d*DIG_W +: DIG_W] != '0) seen = 1'b1;
        else lead = lead + 1'b1;
      end
    end
  end

  assign zero_o  = (frac_i == '0);
  assign shift_o = zero_o ? '0 : lead;
  assign shifted = ext << (DIG_W * shift_o);
  assign frac_o  = shifted[EXT_W-1 -: FW];

  always_comb begin
    if (!zero_o) begin
      a_r3_norm_top: assert (frac_o[FW-1 -: DIG_W] != '0);
    end
  end
endmodule

// File: rtl/hfp_char_adj.sv
module hfp_char_adj #(
  parameter int EXP_W = 7,
  parameter int CNT_W = 4
) (
  input  logic [EXP_W-1:0] char_i,
  input  logic [CNT_W-1:0] shift_i,
  input  logic             zero_i,
  input  logic             sign_i,
  input  logic             um_i,
  output logic [EXP_W-1:0] char_o,
  output logic             sign_o,
  output logic             tzero_o,
  output logic             uf_o
);
  localparam int DW = EXP_W + 2;
  logic [DW-1:0] diff;
  logic          below;

  assign diff  = {2'b00, char_i} - DW'(shift_i);
  assign below = diff[DW-1];

  always_comb begin
    tzero_o = zero_i || (below && !um_i);
    uf_o    = !zero_i && below && um_i;
    char_o  = tzero_o ? '0 : diff[EXP_W-1:0];
    sign_o  = tzero_o ? 1'b0 : sign_i;
  end

  always_comb begin
    if (uf_o) begin
      a_r4_uf_wraps: assert (char_o > char_i);
    end
  end
endmodule

// File: rtl/hfp_reg_chk.sv
module hfp_reg_chk #(
  parameter int REG_W = 4
) (
  input  logic [REG_W-1:0] r1_i,
  input  logic [REG_W-1:0] r2_i,
  output logic             spec_o
);
  function automatic logic bad_reg(input logic [REG_W-1:0] r);
    return r[0] || (r[REG_W-1:1] > 3);
  endfunction

  assign spec_o = bad_reg(r1_i) || bad_reg(r2_i);
endmodule

// File: rtl/hfp_halve.sv
module hfp_halve
  import hfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              fmt_long,
  input  logic [REG_W-1:0]  r1,
  input  logic [REG_W-1:0]  r2,
  input  logic              um_en,
  input  logic [WORD_W-1:0] operand,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] result,
  output logic              wr_en,
  output logic              spec_err,
  output logic              uf_flag
);
  localparam int PAD   = LONG_FW - SHORT_FW;
  localparam int NDIG  = (LONG_FW + DIG_W) / DIG_W;
  localparam int CNT_W = $clog2(NDIG + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // operand unpack, short fraction left-justified in the work width
  logic               op_sign;
  logic [EXP_W-1:0]   op_char;
  logic [LONG_FW-1:0] op_frac;
  always_comb begin
    if (fmt_long) begin
      op_sign = operand[WORD_W-1];
      op_char = operand[WORD_W-2 -: EXP_W];
      op_frac = operand[LONG_FW-1:0];
    end else begin
      op_sign = operand[SHORT_FW+EXP_W];
      op_char = operand[SHORT_FW +: EXP_W];
      op_frac = {operand[SHORT_FW-1:0], {PAD{1'b0}}};
    end
  end

  logic [LONG_FW-1:0] n_frac;
  logic [CNT_W-1:0]   n_shift;
  logic               n_zero;
  hfp_norm #(.FW(LONG_FW), .DIG_W(DIG_W)) u_norm (
    .frac_i (op_frac),
    .frac_o (n_frac),
    .shift_o(n_shift),
    .zero_o (n_zero)
  );

  logic [EXP_W-1:0] a_char;
  logic             a_sign, a_tzero, a_uf;
  hfp_char_adj #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_adj (
    .char_i (op_char),
    .shift_i(n_shift),
    .zero_i (n_zero),
    .sign_i (op_sign),
    .um_i   (um_en),
    .char_o (a_char),
    .sign_o (a_sign),
    .tzero_o(a_tzero),
    .uf_o   (a_uf)
  );

  logic spec;
  hfp_reg_chk #(.REG_W(REG_W)) u_chk (
    .r1_i  (r1),
    .r2_i  (r2),
    .spec_o(spec)
  );

  // result assembly
  hfp_res_t nxt;
  always_comb begin
    nxt.value = '0;
    nxt.wr    = !spec;
    nxt.spec  = spec;
    nxt.uf    = !spec && a_uf;
    if (!spec && !a_tzero) begin
      if (fmt_long) nxt.value = {a_sign, a_char, n_frac};
      else          nxt.value = {{(WORD_W-SHORT_FW-EXP_W-1){1'b0}}, a_sign, a_char,
                                 n_frac[LONG_FW-1 -: SHORT_FW]};
    end
  end

  // output stage: next-state and registers
  logic     vld_q, vld_d;
  logic     load;
  logic     fmt_q;
  hfp_res_t res_q;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      res_q <= nxt;
      fmt_q <= fmt_long;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q.value;
  assign wr_en     = res_q.wr;
  assign spec_err  = res_q.spec;
  assign uf_flag   = res_q.uf;

  // R8: rejected designators never write nor report underflow
  a_r8_spec_no_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && spec_err |-> !wr_en && !uf_flag && result == '0);

  // R9: an accepted request is visible after the edge
  a_r9_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && in_ready |=> out_valid);

  // R10: stalled output holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(uf_flag)
                                && $stable(wr_en));

  // R6/R7: zero fraction field means a positive true zero
  a_r7_zero_plus: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && wr_en &&
    ((fmt_q && result[LONG_FW-1:0] == '0) || (!fmt_q && result[SHORT_FW-1:0] == '0))
    |-> result == '0 && !uf_flag);

  // R1: short results leave the upper half clear
  a_r1_short_upper: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && !fmt_q |-> result[WORD_W-1:32] == '0);
endmodule

// File: tb/test_hfp_halve.sv
module test_hfp_halve;
  localparam time CLK_PER = 10ns;
  localparam int  WD_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, fmt_long, um_en;
  logic [3:0]  r1, r2;
  logic [63:0] operand;
  logic        out_valid, out_ready;
  logic [63:0] result;
  logic        wr_en, spec_err, uf_flag;

  always #(CLK_PER/2) clk = ~clk;

  hfp_halve i_hfp_halve (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fmt_long(fmt_long), .r1(r1), .r2(r2), .um_en(um_en), .operand(operand),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .wr_en(wr_en), .spec_err(spec_err), .uf_flag(uf_flag)
  );

  typedef struct {
    logic [63:0] res;
    logic        wr, spec, uf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit stall_mode = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [67:0] act,
                     input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model: digit loop over fraction plus guard
  function automatic exp_t model(input logic lng, input logic [63:0] op,
                                 input logic um, input string tag);
    exp_t e;
    int fw, ch;
    logic s;
    logic [63:0] fr, ext, msk;
    e.res = '0; e.wr = 1; e.spec = 0; e.uf = 0; e.tag = tag;
    if (lng) begin fw = 56; fr = {8'h0, op[55:0]}; ch = int'(op[62:56]); s = op[63]; end
    else     begin fw = 24; fr = {40'h0, op[23:0]}; ch = int'(op[30:24]); s = op[31]; end
    msk = (64'h1 << (fw + 4)) - 1;
    ext = (fr << 4) >> 1;
    if (ext == 0) return e;
    while (((ext >> fw) & 64'hF) == 0) begin
      ext = (ext << 4) & msk;
      ch--;
    end
    fr = ext >> 4;
    if (ch < 0) begin
      if (!um) return e;
      ch += 128;
      e.uf = 1;
    end
    if (lng) e.res = {s, 7'(ch), fr[55:0]};
    else     e.res = {32'h0, s, 7'(ch), fr[23:0]};
    return e;
  endfunction

  task automatic send(input logic lng, input logic [63:0] op, input logic um,
                      input logic [3:0] a, input logic [3:0] b, input exp_t e);
    fmt_long = lng; operand = op; um_en = um; r1 = a; r2 = b;
    in_valid = 1;
    q.push_back(e);
    forever begin
      @(posedge clk);
      if (in_ready) break;
    end
    @(negedge clk);
    chk(out_valid === 1'b1, "R9 out_valid after accept", {67'h0, out_valid}, 68'h1);
    in_valid = 0;
  endtask

  task automatic send_m(input logic lng, input logic [63:0] op, input logic um,
                        input string tag);
    send(lng, op, um, 4'd2, 4'd4, model(lng, op, um, tag));
  endtask

  task automatic send_x(input logic lng, input logic [63:0] op, input logic um,
                        input logic [63:0] r, input logic u, input string tag);
    exp_t e;
    e.res = r; e.wr = 1; e.spec = 0; e.uf = u; e.tag = tag;
    send(lng, op, um, 4'd0, 4'd6, e);
  endtask

  // monitor: chooses ready, then scores the transfer it enables
  logic [63:0] held_res;
  bit          was_stall = 0;
  initial begin
    out_ready = 1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_stall && out_valid)
          chk(result === held_res, "R10 hold under stall", {4'h0, result}, {4'h0, held_res});
        out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
        was_stall = out_valid && !out_ready;
        held_res  = result;
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            chk(0, "R11 unexpected result", {4'h0, result}, 68'h0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk({result, wr_en, spec_err, uf_flag} === {e.res, e.wr, e.spec, e.uf},
                e.tag, {result, 1'b0, wr_en, spec_err, uf_flag},
                {e.res, 1'b0, e.wr, e.spec, e.uf});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    in_valid = 0; fmt_long = 0; um_en = 0; r1 = 0; r2 = 0; operand = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 reset out_valid", {67'h0, out_valid}, 68'h0);
    chk(in_ready === 1'b1, "R11 reset in_ready", {67'h0, in_ready}, 68'h1);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // hand-worked values
    send_x(0, 64'h0000_0000_4180_0000, 0, 64'h4140_0000, 0, "R2 short 8/2");
    send_x(0, 64'h0000_0000_C1FF_FFFF, 0, 64'hC17F_FFFF, 0, "R2 R7 short neg truncate");
    send_x(0, 64'hDEAD_BEEF_4110_0000, 0, 64'h4080_0000, 0, "R1 R3 short 1/2 upper ignored");
    send_x(0, 64'h0000_0000_4110_0001, 0, 64'h4080_0008, 0, "R3 short guard digit");
    send_x(0, 64'h0000_0000_4201_0000, 0, 64'h4080_0000, 0, "R3 short two digits");
    send_x(1, 64'h4110_0000_0000_0001, 0, 64'h4080_0000_0000_0008, 0, "R1 R3 long guard digit");
    send_x(1, 64'hC180_0000_0000_0000, 0, 64'hC140_0000_0000_0000, 0, "R2 R7 long");
    send_x(0, 64'h0000_0000_0010_0000, 1, 64'h7F80_0000, 1, "R4 short underflow masked in");
    send_x(0, 64'h0000_0000_8010_0000, 1, 64'hFF80_0000, 1, "R4 R7 neg underflow");
    send_x(0, 64'h0000_0000_8010_0000, 0, 64'h0, 0, "R5 R7 underflow to true zero");
    send_x(1, 64'h0010_0000_0000_0000, 0, 64'h0, 0, "R5 long underflow zero");
    send_x(0, 64'h0000_0000_0080_0000, 0, 64'h0040_0000, 0, "R4 R5 char zero no underflow");
    send_x(0, 64'h0000_0000_C500_0000, 1, 64'h0, 0, "R6 R7 zero fraction");
    send_x(1, 64'hFF00_0000_0000_0000, 1, 64'h0, 0, "R6 long zero fraction");

    // designator checks
    e.res = '0; e.wr = 0; e.spec = 1; e.uf = 0; e.tag = "R8 odd r1";
    send(0, 64'h4110_0000, 0, 4'd1, 4'd2, e);
    e.tag = "R8 r2 too high";
    send(1, 64'h0010_0000_0000_0000, 1, 4'd6, 4'd8, e);
    e.tag = "R8 r1 high even";
    send(0, 64'h4110_0000, 0, 4'd14, 4'd0, e);

    // sweep with consumer stalls
    stall_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] op;
      logic lng, um;
      op = {$urandom, $urandom};
      lng = $urandom % 2;
      um = $urandom % 2;
      if (i % 4 == 1) op[62:56] = op[62:56] & 7'h03;
      if (i % 4 == 1) op[30:24] = op[30:24] & 7'h03;
      if (i % 8 == 3) op[55:0] = op[55:0] >> (4 * ($urandom % 14));
      if (i % 8 == 5) op[23:0] = op[23:0] >> (4 * ($urandom % 6));
      send_m(lng, op, um, "R1 R2 R3 R4 R5 R6 R7 R11 sweep");
    end

    while (q.size() != 0) @(negedge clk);
    stall_mode = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule